// File: doc/BRIEF.md
# Repeat-Accumulate Block Encoder

This block turns a frame of information bits into a rate-1/q repeat-accumulate codeword. Every information bit is copied q times, and the copies are laid down in natural order in a one-bit-wide frame buffer of K·q entries. The buffer is then read out in an order set by a linear congruential permutation, pi(j) = (a·j + b) mod N with N = K·q. The permuted stream feeds a one-bit recursive accumulator, so each coded bit is the permuted bit XOR the coded bit that came before it. The accumulator starts each frame at zero. With the default parameters (K = 64, q = 3, a = 25, b = 7) a frame of 64 bits becomes 192 coded bits.

Information bits enter on a valid/ready stream in which a start-of-frame flag marks the first bit. Coded bits leave on a valid/ready stream with an end-of-frame flag on the last one. A single buffer is shared between loading and draining, so the input is held off while a codeword is being sent. The next frame is taken once the last coded bit of the current one has been handed over.

The control is a three-state machine. IDLE waits for a start beat. LOAD collects the remaining K−1 bits. DRAIN sends N coded bits. The transitions are: IDLE→LOAD on an accepted start beat (or IDLE→DRAIN when K = 1), LOAD→DRAIN on acceptance of bit K−1, DRAIN→IDLE on the handshake of the last coded bit. Each state otherwise stays where it is.

Top module: `ra_encoder`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `out_eof` is 0.
- R2: In IDLE, an input beat with `in_sof` = 0 is accepted and dropped. It starts no frame and produces no output.
- R3: A frame is the accepted beat with `in_sof` = 1 plus the next K−1 accepted beats. `in_sof` on those later beats is ignored and counted as data.
- R4: Information bit m (m = 0 for the start beat) occupies positions m·q through m·q+q−1 of the N-bit repeated sequence r.
- R5: Coded bit j (j = 0 first) uses the repeated bit r[pi(j)], where pi(j) = (a·j + b) mod N.
- R6: Coded bit c_j = r[pi(j)] XOR c_{j−1}, with c_{−1} = 0 at the start of every frame.
- R7: Each frame yields exactly N coded bits. `out_eof` is 1 on bit N−1 only.
- R8: `in_ready` is 0 from the cycle after the last information bit is accepted until the last coded bit's handshake. It is 1 again in the cycle after that handshake.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_eof` hold their values into the next cycle.
- R10: `out_valid` is 0 in IDLE and LOAD, whatever the value of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Encoder can take a bit |
| in_data | input | 1 | Information bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| out_valid | output | 1 | Coded bit offered |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_data | output | 1 | Coded bit |
| out_eof | output | 1 | Marks the last coded bit of a frame |

## Verification
The bench goes after the following corner cases.
- Frame boundaries under back-pressure. A wrapped permutation step would send bits in the wrong order, and an accumulator not cleared between frames would invert every later codeword of a frame that follows a frame ending in 1.
- Stray start flags in the middle of a frame and loose beats sent before a frame. A design that restarts on them, or that treats junk as a start, shifts the whole codeword.
- Random stalls on the output. A design that advances the read address or the accumulator without a handshake would drop or duplicate coded bits.
- Back-to-back frames. An early-raised `in_ready` would overwrite the buffer in the middle of a drain.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2
    } ra_state_e;

endpackage

// File: rtl/ra_perm_gen.sv
// Produces pi(j) = (MULT*j + OFFS) mod N one step at a time.
module ra_perm_gen #(
    parameter int N    = 192,
    parameter int MULT = 25,
    parameter int OFFS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 step,
    output logic [$clog2(N)-1:0] addr
);
    localparam int AW = $clog2(N);
    localparam logic [AW:0] STEP_V  = (AW+1)'(MULT % N);
    localparam logic [AW:0] START_V = (AW+1)'(OFFS % N);
    localparam logic [AW:0] N_V     = (AW+1)'(N);

    logic [AW-1:0] addr_q;
    logic [AW:0]   sum;
    logic [AW:0]   wrapped;

    always_comb begin
        sum     = {1'b0, addr_q} + STEP_V;
        wrapped = (sum >= N_V) ? (sum - N_V) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= START_V[AW-1:0];
        end else if (init) begin
            addr_q <= START_V[AW-1:0];
        end else if (step) begin
            addr_q <= wrapped[AW-1:0];
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/ra_rep_buf.sv
// Frame buffer: one write lays down REP copies of a bit.
module ra_rep_buf #(
    parameter int N   = 192,
    parameter int REP = 3
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wbase,
    input  logic                 din,
    input  logic [$clog2(N)-1:0] raddr,
    output logic                 dout
);
    localparam int AW = $clog2(N);

    logic [N-1:0] mem;

    always_ff @(posedge clk) begin
        if (we) begin
            for (int r = 0; r < REP; r++) begin
                mem[wbase + AW'(r)] <= din;
            end
        end
    end

    assign dout = mem[raddr];
endmodule

// File: rtl/ra_accum.sv
// Two-state recursive inner code: out = in XOR previous out.
module ra_accum (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic dout,
    output logic state
);
    logic state_q;

    assign dout  = din ^ state_q;
    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else if (clr) begin
            state_q <= 1'b0;
        end else if (en) begin
            state_q <= dout;
        end
    end
endmodule

// File: rtl/ra_ctrl.sv
// Frame sequencer: IDLE -> LOAD -> DRAIN -> IDLE.
module ra_ctrl
    import ra_pkg::*;
#(
    parameter int K   = 64,
    parameter int REP = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic                       out_ready,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic                       out_eof,
    output logic                       wr_en,
    output logic [$clog2(K*REP)-1:0]   wr_base,
    output logic                       perm_init,
    output logic                       perm_step,
    output logic                       acc_clr,
    output logic                       acc_en
);
    localparam int N  = K * REP;
    localparam int AW = $clog2(N);
    localparam int CW = $clog2(K + 1);
    localparam logic [CW-1:0] LAST_IN  = CW'(K - 1);
    localparam logic [AW-1:0] LAST_OUT = AW'(N - 1);
    localparam logic [AW-1:0] REP_V    = AW'(REP);

    ra_state_e     state_q, state_d;
    logic [CW-1:0] in_cnt_q;
    logic [AW-1:0] out_cnt_q;
    logic [AW-1:0] wr_ptr_q;
    logic          in_fire, out_fire;

    assign in_fire  = in_valid & in_ready;
    assign out_fire = out_valid & out_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            wr_ptr_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && in_fire && in_sof) begin
                in_cnt_q  <= CW'(1);
                wr_ptr_q  <= REP_V;
                out_cnt_q <= '0;
            end else if (state_q == ST_LOAD && in_fire) begin
                in_cnt_q <= in_cnt_q + CW'(1);
                wr_ptr_q <= wr_ptr_q + REP_V;
            end
            if (out_fire) begin
                out_cnt_q <= out_cnt_q + AW'(1);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_eof   = 1'b0;
        wr_en     = 1'b0;
        wr_base   = '0;
        perm_init = 1'b0;
        perm_step = 1'b0;
        acc_clr   = 1'b0;
        acc_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && in_sof) begin
                    wr_en     = 1'b1;
                    perm_init = 1'b1;
                    acc_clr   = 1'b1;
                    state_d   = (K == 1) ? ST_DRAIN : ST_LOAD;
                end
            end
            ST_LOAD: begin
                in_ready = 1'b1;
                wr_base  = wr_ptr_q;
                if (in_valid) begin
                    wr_en = 1'b1;
                    if (in_cnt_q == LAST_IN) state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_eof   = (out_cnt_q == LAST_OUT);
                if (out_ready) begin
                    perm_step = 1'b1;
                    acc_en    = 1'b1;
                    if (out_eof) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ra_encoder.sv
module ra_encoder #(
    parameter int K    = 64,
    parameter int REP  = 3,
    parameter int MULT = 25,
    parameter int OFFS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_data,
    input  logic in_sof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_data,
    output logic out_eof
);
    localparam int N  = K * REP;
    localparam int AW = $clog2(N);

    logic          wr_en, perm_init, perm_step, acc_clr, acc_en;
    logic [AW-1:0] wr_base, rd_addr;
    logic          buf_bit;
    logic          acc_state;

    ra_ctrl #(.K(K), .REP(REP)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_eof   (out_eof),
        .wr_en     (wr_en),
        .wr_base   (wr_base),
        .perm_init (perm_init),
        .perm_step (perm_step),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en)
    );

    ra_rep_buf #(.N(N), .REP(REP)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .wbase (wr_base),
        .din   (in_data),
        .raddr (rd_addr),
        .dout  (buf_bit)
    );

    ra_perm_gen #(.N(N), .MULT(MULT), .OFFS(OFFS)) u_perm (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (perm_init),
        .step  (perm_step),
        .addr  (rd_addr)
    );

    ra_accum u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .din   (buf_bit),
        .dout  (out_data),
        .state (acc_state)
    );
endmodule

// File: rtl/ra_encoder_chk.sv
module ra_encoder_chk #(
    parameter int N = 192
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_data,
    input logic out_eof,
    input logic acc_state
);
    localparam int AW = $clog2(N + 1);
    logic [AW-1:0] beat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              beat_cnt <= '0;
        else if (out_valid && out_ready && out_eof) beat_cnt <= '0;
        else if (out_valid && out_ready)         beat_cnt <= beat_cnt + AW'(1);
    end

    a_r8_no_input_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r8_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> (in_ready && !out_valid));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    a_r7_eof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    a_r7_eof_position: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> (beat_cnt == AW'(N - 1)));

    a_r6_running_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof) |=> (acc_state == $past(out_data)));

    a_r6_frame_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (acc_state == 1'b0));
endmodule

bind ra_encoder ra_encoder_chk #(.N(K * REP)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eof   (out_eof),
    .acc_state (acc_state)
);

// File: tb/ra_encoder_tb.sv
`timescale 1ns/1ps
module ra_encoder_tb_top;
    localparam int K  = 64;
    localparam int Q  = 3;
    localparam int N  = K * Q;
    localparam int PA = 25;
    localparam int PB = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_data, out_eof;

    int errors = 0, checks = 0;
    int frames_sent = 0, frames_out = 0;
    bit stall_mode = 0;
    bit mon_on = 0;
    int cycles = 0;

    bit exp_q[$];
    bit eof_q[$];
    bit m_loading = 0;
    int m_cnt = 0;
    bit m_bits[K];
    bit prev_hold = 0, prev_data = 0, prev_eof = 0;

    always #2.5 clk = ~clk;

    ra_encoder #(.K(K), .REP(Q), .MULT(PA), .OFFS(PB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Behavioural model: repeat, permute, running XOR.
    task automatic push_codeword();
        bit rep[N];
        bit c;
        for (int m = 0; m < N; m++) rep[m] = m_bits[m / Q];
        c = 0;
        for (int j = 0; j < N; j++) begin
            c = c ^ rep[(PA * j + PB) % N];
            exp_q.push_back(c);
            eof_q.push_back(j == N - 1);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) cycles++;
        if (rst_n && mon_on) begin
            out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
            chk(in_ready == (exp_q.size() == 0), "R8 in_ready", in_ready, exp_q.size() == 0);
            chk(out_valid == (exp_q.size() != 0), "R10 out_valid", out_valid, exp_q.size() != 0);
            if (prev_hold) begin
                chk(out_data == prev_data, "R9 data hold", out_data, prev_data);
                chk(out_eof == prev_eof, "R9 eof hold", out_eof, prev_eof);
            end
            if (out_valid && out_ready && exp_q.size() != 0) begin
                chk(out_data == exp_q[0], "R4/R5/R6 coded bit", out_data, exp_q[0]);
                chk(out_eof == eof_q[0], "R7 eof flag", out_eof, eof_q[0]);
                if (eof_q[0]) frames_out++;
                void'(exp_q.pop_front());
                void'(eof_q.pop_front());
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            prev_eof  = out_eof;
            if (in_valid && in_ready) begin
                if (!m_loading) begin
                    if (in_sof) begin
                        m_bits[0] = in_data;
                        m_cnt = 1;
                        m_loading = 1;
                    end
                end else begin
                    m_bits[m_cnt] = in_data;
                    m_cnt++;
                end
                if (m_loading && m_cnt == K) begin
                    m_loading = 0;
                    push_codeword();
                end
            end
        end
    end

    task automatic send_beat(input bit d, input bit s);
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = s;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [K-1:0] bits, input bit stray_sof, input bit gaps);
        for (int i = 0; i < K; i++) begin
            send_beat(bits[i], (i == 0) || (stray_sof && ($urandom % 4 == 0)));
            if (gaps && ($urandom % 5 == 0)) idle(1);
        end
        frames_sent++;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || m_loading) idle(1);
        idle(3);
    endtask

    function automatic logic [K-1:0] rnd_bits();
        logic [K-1:0] v;
        for (int i = 0; i < K; i += 32) v[i +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                summary();
            end
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(out_eof == 1'b0, "R1 reset out_eof", out_eof, 0);
        @(posedge clk); #1;
        mon_on = 1;

        // all zeros, all ones, impulse at bit 0 and at the last bit
        send_frame('0, 0, 0);             wait_drain();
        send_frame('1, 0, 0);             wait_drain();
        send_frame(K'(1), 0, 0);          wait_drain();
        send_frame({1'b1, {(K-1){1'b0}}}, 0, 1); wait_drain();

        // R2: loose beats before a frame are dropped
        for (int i = 0; i < 5; i++) send_beat(1'b1, 1'b0);
        idle(2);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 no output from junk", out_valid, 0);
        chk(in_ready == 1'b1, "R2 still idle", in_ready, 1);
        @(posedge clk); #1;
        send_frame(rnd_bits(), 0, 1);     wait_drain();

        // R3: stray start flags inside frames
        send_frame(rnd_bits(), 1, 0);     wait_drain();
        send_frame(rnd_bits(), 1, 1);     wait_drain();

        // back-to-back frames with output stalls
        stall_mode = 1;
        for (int f = 0; f < 6; f++) send_frame(rnd_bits(), f[0], f[1]);
        wait_drain();
        stall_mode = 0;
        wait_drain();

        chk(frames_out == frames_sent, "R3/R7 frame count", frames_out, frames_sent);
        summary();
    end
endmodule